// File: doc/BRIEF.md
# Priority-Level Maskable Interrupt Controller

This block collects one-cycle request pulses from a parameterised number of maskable interrupt sources. Each pulse is held in a per-source pending flag. Each source also has a 3-bit priority level set by software. Two global settings decide whether a pending source may interrupt the processor: a master enable bit and a 3-bit processor threshold.

In every idle cycle the block searches the eligible pending sources for the highest level and registers the winner. It then offers that source's index and level to the CPU through a valid/acknowledge pair. When the CPU acknowledges, the block clears the winning source's pending flag and drops the offer. A small register port lets software write levels, the enable bit and the threshold. Software can also clear pending flags through this port and read all of this state back.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, `irq_valid` is 0 and every register reads 0: enable, threshold, all pending flags and all levels.
- R2: The register map is fixed. Address 0 holds the enable in bit 0. Address 1 holds the threshold in bits [2:0]. Address 2+i belongs to source i, with the pending flag in bit 0 and the level in bits [3:1]. Reads of any other address return 0.
- R3: A one-cycle pulse on `src_req[i]` sets source i's pending flag at the next clock edge.
- R4: A source whose level is 0 is never offered, even while its flag is pending.
- R5: While the enable bit is 0, no source is offered. Pending flags are kept, and a source becomes eligible again once the enable bit returns to 1.
- R6: A source is offered only if its level is strictly greater than the threshold. A threshold of 7 therefore blocks every source.
- R7: Among eligible pending sources, the one with the highest level is offered. When levels tie, the lowest index is offered.
- R8: `irq_valid` rises one edge after the flag of an eligible source becomes visible. While `irq_valid` is 1 and `irq_ack` is 0, `irq_idx` and `irq_lvl` hold their values, even if a higher-level request arrives.
- R9: An edge with `irq_valid` and `irq_ack` both at 1 clears the offered source's flag and drops `irq_valid`. `irq_ack` has no effect while `irq_valid` is 0.
- R10: A register write to source i's address with bit 0 at 0 clears its flag. A write with bit 0 at 1 leaves the flag unchanged. Both kinds of write load the level.
- R11: If a hardware pulse and a clear (by software write or by acknowledge) hit the same flag in the same cycle, the flag ends up at 1.
- R12: Writing the enable, the threshold or one source's register changes no other stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NUM_SRC | One-cycle request pulse per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |
| irq_valid | output | 1 | An interrupt is being offered |
| irq_idx | output | IDX_W | Index of the offered source |
| irq_lvl | output | 3 | Level of the offered source |
| irq_ack | input | 1 | CPU acceptance, one cycle |

## Verification
Every flag, level and global setting can be read on `reg_rdata` in the same cycle. A wrong stored bit therefore shows up at the next read of its address, whatever the arbiter is doing. A fault in eligibility or ordering shows up on `irq_valid`, `irq_idx` and `irq_lvl` exactly one edge after the deciding flag or setting changes. The bench samples at that edge and again several cycles later, to catch both late offers and spurious ones. Faults in the hold logic or in acknowledge clearing show in the cycle after the acknowledge: either the offer stays up, or the flag is still set when it is read back.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int LVL_W = 3;
   typedef logic [LVL_W-1:0] lvl_t;
   localparam lvl_t LVL_OFF = '0;
   localparam lvl_t LVL_TOP = '1;
endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC-1:0]       hw_set,
   input  logic [NUM_SRC-1:0]       sw_sel,
   input  logic                     sw_keep,
   input  lvl_t                     sw_lvl,
   input  logic [NUM_SRC-1:0]       ack_clr,
   output logic [NUM_SRC-1:0]       pend_q,
   output lvl_t [NUM_SRC-1:0]       lvl_q
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic clr_now;
      assign clr_now = (sw_sel[i] && !sw_keep) || ack_clr[i];

      // hardware set has priority over any clear
      always_ff @(posedge clk) begin
         if (!rst_n)          pend_q[i] <= 1'b0;
         else if (hw_set[i])  pend_q[i] <= 1'b1;
         else if (clr_now)    pend_q[i] <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)          lvl_q[i] <= LVL_OFF;
         else if (sw_sel[i])  lvl_q[i] <= sw_lvl;
      end

      // R3 / R11: a pulse always leaves the flag set
      a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         hw_set[i] |=> pend_q[i]);
      // R10: nothing but a hardware pulse can raise a flag
      a_r10_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
         (!pend_q[i] && !hw_set[i]) |=> !pend_q[i]);
      // R12: level changes only by a write to its own address
      a_r12_lvl_own: assert property (@(posedge clk) disable iff (!rst_n)
         !sw_sel[i] |=> $stable(lvl_q[i]));
   end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     glb_en,
   input  lvl_t                     thr,
   input  logic [NUM_SRC-1:0]       pend,
   input  lvl_t [NUM_SRC-1:0]       lvl,
   output logic                     win_vld,
   output logic [IDX_W-1:0]         win_idx,
   output lvl_t                     win_lvl
);
   // scan upward; strict compare keeps the lowest index on a tie
   always_comb begin
      win_vld = 1'b0;
      win_idx = '0;
      win_lvl = LVL_OFF;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (glb_en && pend[i] && (lvl[i] > thr) && (lvl[i] > win_lvl)) begin
            win_vld = 1'b1;
            win_idx = IDX_W'(i);
            win_lvl = lvl[i];
         end
      end
   end

   // R6: a threshold at the top level admits nothing
   a_r6_top_masks: assert property (@(posedge clk) disable iff (!rst_n)
      (thr == LVL_TOP) |-> !win_vld);
   // R5: disabled controller nominates nothing
   a_r5_en_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> !win_vld);
   // R4: a nominee never has level zero and is pending
   a_r4_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      win_vld |-> (win_lvl != LVL_OFF) && pend[win_idx]);
endmodule

// File: rtl/irqc_offer.sv
module irqc_offer
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     win_vld,
   input  logic [IDX_W-1:0]         win_idx,
   input  lvl_t                     win_lvl,
   input  logic                     ack,
   output logic                     off_vld,
   output logic [IDX_W-1:0]         off_idx,
   output lvl_t                     off_lvl,
   output logic [NUM_SRC-1:0]       ack_clr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_vld <= 1'b0;
         off_idx <= '0;
         off_lvl <= LVL_OFF;
      end else if (off_vld) begin
         if (ack) off_vld <= 1'b0;
      end else if (win_vld) begin
         off_vld <= 1'b1;
         off_idx <= win_idx;
         off_lvl <= win_lvl;
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
      assign ack_clr[i] = off_vld && ack && (off_idx == IDX_W'(i));
   end

   // R8: offer is frozen until acknowledged
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (off_vld && !ack) |=> off_vld && $stable(off_idx) && $stable(off_lvl));
   // R9: acknowledge drops the offer
   a_r9_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (off_vld && ack) |=> !off_vld);
   // R9: at most one source is cleared per acknowledge
   a_r9_one_clr: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_clr));
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int DATA_W  = 8,
   parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   parameter int ADDR_W  = $clog2(NUM_SRC + 2)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC-1:0]       src_req,
   input  logic                     reg_we,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   output logic                     irq_valid,
   output logic [IDX_W-1:0]         irq_idx,
   output logic [LVL_W-1:0]         irq_lvl,
   input  logic                     irq_ack
);
   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(1);
   localparam int                A_SRC = 2;

   if (NUM_SRC < 1)                 begin : g_bad_n   $error("NUM_SRC must be at least 1"); end
   if (DATA_W < LVL_W + 1)          begin : g_bad_w   $error("DATA_W too small for a source register"); end
   if ((1 << IDX_W) < NUM_SRC)      begin : g_bad_i   $error("IDX_W too small"); end
   if ((1 << ADDR_W) < NUM_SRC + 2) begin : g_bad_a   $error("ADDR_W too small"); end

   if (DATA_W > LVL_W + 1) begin : g_spare
      logic unused_wdata;
      assign unused_wdata = ^reg_wdata[DATA_W-1:LVL_W+1];
   end

   logic                en_q;
   lvl_t                thr_q;
   logic [NUM_SRC-1:0]  pend_q;
   lvl_t [NUM_SRC-1:0]  lvl_q;
   logic [NUM_SRC-1:0]  sw_sel;
   logic [NUM_SRC-1:0]  ack_clr;
   logic                win_vld;
   logic [IDX_W-1:0]    win_idx;
   lvl_t                win_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         thr_q <= LVL_OFF;
      end else if (reg_we) begin
         if (reg_addr == A_EN)  en_q  <= reg_wdata[0];
         if (reg_addr == A_THR) thr_q <= reg_wdata[LVL_W-1:0];
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
      assign sw_sel[i] = reg_we && (reg_addr == ADDR_W'(A_SRC + i));
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_EN)       reg_rdata[0] = en_q;
      else if (reg_addr == A_THR) reg_rdata[LVL_W-1:0] = thr_q;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (reg_addr == ADDR_W'(A_SRC + i)) reg_rdata[LVL_W:0] = {lvl_q[i], pend_q[i]};
      end
   end

   irqc_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (src_req),
      .sw_sel  (sw_sel),
      .sw_keep (reg_wdata[0]),
      .sw_lvl  (reg_wdata[LVL_W:1]),
      .ack_clr (ack_clr),
      .pend_q  (pend_q),
      .lvl_q   (lvl_q)
   );

   irqc_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .glb_en  (en_q),
      .thr     (thr_q),
      .pend    (pend_q),
      .lvl     (lvl_q),
      .win_vld (win_vld),
      .win_idx (win_idx),
      .win_lvl (win_lvl)
   );

   irqc_offer #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_offer (
      .clk     (clk),
      .rst_n   (rst_n),
      .win_vld (win_vld),
      .win_idx (win_idx),
      .win_lvl (win_lvl),
      .ack     (irq_ack),
      .off_vld (irq_valid),
      .off_idx (irq_idx),
      .off_lvl (irq_lvl),
      .ack_clr (ack_clr)
   );

   // R6: a fresh offer clears the threshold and the enable of its capture edge
   a_r6_fresh_above: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_valid) |-> (irq_lvl > $past(thr_q)) && $past(en_q));
   // R9: acknowledged flag is gone unless re-pulsed
   a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_ack && !src_req[irq_idx]) |=> !pend_q[$past(irq_idx)]);
   // R12: global settings move only on their own writes
   a_r12_glb_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && (reg_addr == A_EN || reg_addr == A_THR)) |=> $stable(en_q) && $stable(thr_q));
endmodule

// File: tb/irq_level_ctrl_bench.sv
`timescale 1ns/1ps
module irq_level_ctrl_bench;
   localparam int NS = 8;
   localparam int DW = 8;
   localparam int IW = 3;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_req = '0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq_valid;
   logic [IW-1:0] irq_idx;
   logic [2:0]    irq_lvl;
   logic          irq_ack = 1'b0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   irq_level_ctrl #(.NUM_SRC(NS), .DATA_W(DW)) u_irq_level_ctrl (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_valid(irq_valid), .irq_idx(irq_idx), .irq_lvl(irq_lvl), .irq_ack(irq_ack));

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; src_req = '0; reg_we = 1'b0; irq_ack = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      reg_addr = AW'(a);
      #0.5;
      d = int'(reg_rdata);
   endtask

   task automatic src_cfg(input int i, input int lvl);
      wr(2 + i, (lvl << 1) | 1);
   endtask

   task automatic pulse(input logic [NS-1:0] m);
      @(negedge clk);
      src_req = m;
      @(negedge clk);
      src_req = '0;
   endtask

   task automatic ack_once();
      @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic t_reset();
      int d;
      do_reset();
      chk("R1 valid", irq_valid, 0);
      for (int a = 0; a < NS + 2; a++) begin
         rd(a, d);
         chk("R1 reg", d, 0);
      end
      rd(NS + 2, d);
      chk("R2 unmapped", d, 0);
   endtask

   task automatic t_basic();
      int d;
      do_reset();
      wr(0, 1);
      src_cfg(3, 5);
      pulse(8'h08);
      rd(5, d);
      chk("R3 flag set", d, (5 << 1) | 1);
      chk("R8 not yet", irq_valid, 0);
      @(negedge clk);
      chk("R8 valid", irq_valid, 1);
      chk("R8 idx", irq_idx, 3);
      chk("R8 lvl", irq_lvl, 5);
      repeat (3) @(negedge clk);
      chk("R8 held", irq_valid, 1);
      chk("R8 held idx", irq_idx, 3);
      ack_once();
      chk("R9 drop", irq_valid, 0);
      rd(5, d);
      chk("R9 flag cleared", d, 5 << 1);
      repeat (2) @(negedge clk);
      chk("R9 no reoffer", irq_valid, 0);
      ack_once();
      chk("R9 idle ack", irq_valid, 0);
      rd(5, d);
      chk("R9 idle ack keeps", d, 5 << 1);
   endtask

   task automatic t_level_zero();
      int d;
      do_reset();
      wr(0, 1);
      pulse(8'h02);
      repeat (3) @(negedge clk);
      chk("R4 lvl0 blocked", irq_valid, 0);
      rd(3, d);
      chk("R4 flag kept", d, 1);
   endtask

   task automatic t_enable();
      int d;
      do_reset();
      src_cfg(3, 5);
      pulse(8'h08);
      repeat (3) @(negedge clk);
      chk("R5 disabled", irq_valid, 0);
      rd(5, d);
      chk("R5 flag kept", d & 1, 1);
      wr(0, 1);
      chk("R5 not yet", irq_valid, 0);
      @(negedge clk);
      chk("R5 enabled", irq_valid, 1);
      chk("R5 idx", irq_idx, 3);
   endtask

   task automatic t_threshold();
      int d;
      do_reset();
      wr(0, 1);
      wr(1, 5);
      src_cfg(3, 5);
      pulse(8'h08);
      repeat (3) @(negedge clk);
      chk("R6 equal blocked", irq_valid, 0);
      wr(1, 4);
      @(negedge clk);
      chk("R6 above passes", irq_valid, 1);
      chk("R6 lvl", irq_lvl, 5);
      ack_once();
      wr(1, 7);
      src_cfg(6, 7);
      pulse(8'h40);
      repeat (3) @(negedge clk);
      chk("R6 thr7 masks", irq_valid, 0);
      rd(8, d);
      chk("R6 flag kept", d, (7 << 1) | 1);
   endtask

   task automatic t_priority();
      do_reset();
      src_cfg(2, 4);
      src_cfg(5, 6);
      src_cfg(6, 6);
      pulse(8'h64);
      wr(0, 1);
      @(negedge clk);
      chk("R7 first idx", irq_idx, 5);
      chk("R7 first lvl", irq_lvl, 6);
      ack_once();
      @(negedge clk);
      chk("R7 second idx", irq_idx, 6);
      ack_once();
      @(negedge clk);
      chk("R7 third idx", irq_idx, 2);
      chk("R7 third lvl", irq_lvl, 4);
      ack_once();
      @(negedge clk);
      chk("R7 drained", irq_valid, 0);
   endtask

   task automatic t_hold_vs_higher();
      do_reset();
      wr(0, 1);
      src_cfg(3, 3);
      src_cfg(4, 7);
      pulse(8'h08);
      @(negedge clk);
      chk("R8 low offered", irq_idx, 3);
      pulse(8'h10);
      @(negedge clk);
      chk("R8 stays low", irq_idx, 3);
      chk("R8 stays lvl", irq_lvl, 3);
      ack_once();
      chk("R9 gap", irq_valid, 0);
      @(negedge clk);
      chk("R7 higher next", irq_idx, 4);
   endtask

   task automatic t_sw_clear();
      int d;
      do_reset();
      pulse(8'h01);
      wr(2, 6 << 1);
      rd(2, d);
      chk("R10 clear by 0", d, 6 << 1);
      wr(2, (3 << 1) | 1);
      rd(2, d);
      chk("R10 one no set", d, 3 << 1);
      pulse(8'h01);
      wr(2, (2 << 1) | 1);
      rd(2, d);
      chk("R10 one keeps", d, (2 << 1) | 1);
   endtask

   task automatic t_race();
      int d;
      do_reset();
      @(negedge clk);
      src_req = 8'h80; reg_we = 1'b1; reg_addr = AW'(9); reg_wdata = DW'(4 << 1);
      @(negedge clk);
      src_req = '0; reg_we = 1'b0;
      rd(9, d);
      chk("R11 set beats sw clear", d, (4 << 1) | 1);
      wr(0, 1);
      @(negedge clk);
      chk("R11 offered", irq_idx, 7);
      @(negedge clk);
      irq_ack = 1'b1; src_req = 8'h80;
      @(negedge clk);
      irq_ack = 1'b0; src_req = '0;
      chk("R11 ack drops", irq_valid, 0);
      rd(9, d);
      chk("R11 set beats ack", d & 1, 1);
      @(negedge clk);
      chk("R11 reoffer", irq_valid, 1);
   endtask

   task automatic t_independent();
      int d;
      do_reset();
      src_cfg(1, 5);
      wr(0, 1);
      wr(1, 6);
      rd(0, d);
      chk("R12 en", d, 1);
      rd(3, d);
      chk("R12 src1", d, (5 << 1));
      wr(0, 0);
      rd(1, d);
      chk("R12 thr", d, 6);
      src_cfg(4, 2);
      rd(3, d);
      chk("R12 neighbour", d, 5 << 1);
      rd(1, d);
      chk("R12 thr kept", d, 6);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_level_zero();
      t_enable();
      t_threshold();
      t_priority();
      t_hold_vs_higher();
      t_sw_clear();
      t_race();
      t_independent();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule